// File: doc/BRIEF.md
# DMA Control/Status Register File

This block is the host-facing register file that steers an endpoint's two DMA directions. The host programs four 32-bit address registers and a coded transfer-size field, then starts a direction by setting its run bit. The run bits feed straight into the transmit and receive engines. No engine state machine may leave idle unless its run bit is high. A "write" DMA moves data from the endpoint into host memory. A "read" DMA fetches data from host memory into the endpoint. Both directions may be active at the same time.

When an engine reports completion with a one-cycle done pulse, the register file clears that engine's run bit. It also records the completion in a sticky status bit, which the host clears by writing a one to it. The transfer size is not a free byte count. A 3-bit policy code selects one of six DWORD counts, and the block decodes that code into a count for the engines.

The register file answers only when the host access falls in its own base-address window, signalled by a window-select input. Accesses aimed at the user-logic window leave it untouched.

Top module: `dma_csr_top`

## Requirements
- R1: After reset, every register reads zero, both run outputs are low, all four address outputs are zero and the transfer count is 1024.
- R2: Byte offsets 0x08, 0x0C, 0x10 and 0x14 hold, in that order, the host destination address, the host source address, the local destination address and the local source address. Each is a full 32-bit register, reads back what was written, and drives its address output from the cycle after the write.
- R3: Offset 0x18 holds the length-policy code in bits [2:0], and its other bits read zero. Codes 0 to 5 give a transfer count of 1024, 2048, 3072, 4096, 8192 and 16384 DWORDs. Codes 6 and 7 give 1024.
- R4: Offset 0x00 is the control register. Bit 0 is the write-DMA run bit and bit 1 is the read-DMA run bit, and the run outputs follow them. A host write of 1 starts a direction and a write of 0 stops it.
- R5: A done pulse from an engine clears that direction's run bit on the next cycle. A host write to the control register in the same cycle takes precedence over the done pulse.
- R6: A done pulse sets the matching sticky bit at offset 0x04 (bit 0 for write DMA, bit 1 for read DMA). Writing 1 to a sticky bit clears it, and writing 0 leaves it unchanged. A done pulse and a clearing write in the same cycle leave the bit set.
- R7: Offsets that are not DWORD-aligned, or that name no register, read zero, and writes to them change nothing.
- R8: While the window-select input is low, host writes change nothing and host reads return zero.
- R9: The two directions are independent. Both run bits can be high together, and a done pulse on one direction leaves the other's run bit and sticky bit unchanged.
- R10: Read data appears on the cycle after the read strobe. On any cycle that follows one without a read strobe, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 1 | Host access targets this register window |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | ADDR_W | Byte offset within the window |
| hostWdata | input | DATA_W | Host write data |
| hostRdata | output | DATA_W | Registered read data |
| wrDmaDone | input | 1 | Write-DMA engine done pulse |
| rdDmaDone | input | 1 | Read-DMA engine done pulse |
| wrDmaRun | output | 1 | Write-DMA engine enable |
| rdDmaRun | output | 1 | Read-DMA engine enable |
| hostDstAddr | output | DATA_W | Host destination address |
| hostSrcAddr | output | DATA_W | Host source address |
| localDstAddr | output | DATA_W | Local destination address |
| localSrcAddr | output | DATA_W | Local source address |
| xferDwords | output | XFER_W | Decoded DWORDs per DMA operation |

## Verification
The bench drives a done pulse and a control write in the same cycle. A design that gave the done pulse priority would drop a restart the host has just issued. It also collides a done pulse with a write-one-to-clear of the same sticky bit. Here, reversing the priority would lose a completion.

It walks all eight policy codes, so a decoder that mishandled the two spare codes would hand an engine an undefined count. It also probes misaligned offsets, offsets past the map and accesses with the window deselected. A decoder that masked low address bits, or ignored the window input, would corrupt the address registers there.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;

  localparam int XFER_W = 15;
  localparam int LEN_CODE_W = 3;

  // Byte offsets of the registers inside the window
  localparam int OFF_CTRL = 'h00;
  localparam int OFF_STAT = 'h04;
  localparam int OFF_HDST = 'h08;
  localparam int OFF_HSRC = 'h0C;
  localparam int OFF_LDST = 'h10;
  localparam int OFF_LSRC = 'h14;
  localparam int OFF_LEN  = 'h18;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_STAT, SEL_HDST,
    SEL_HSRC, SEL_LDST, SEL_LSRC, SEL_LEN
  } regPick_e;

  // Strobes from the decoder to the register datapath
  typedef struct packed {
    logic     wrCtrl;
    logic     wrStat;
    logic [3:0] wrCfg;   // hostDst, hostSrc, localDst, localSrc
    logic     wrLen;
    logic     rdStrobe;
    regPick_e rdPick;
  } csrStrobe_t;

  function automatic logic [XFER_W-1:0] policyDwords(input logic [LEN_CODE_W-1:0] code);
    logic [XFER_W-1:0] n;
    case (code)
      3'd1:    n = XFER_W'(2048);
      3'd2:    n = XFER_W'(3072);
      3'd3:    n = XFER_W'(4096);
      3'd4:    n = XFER_W'(8192);
      3'd5:    n = XFER_W'(16384);
      default: n = XFER_W'(1024);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              regSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  output csrStrobe_t        strobe
);

  regPick_e pick;
  logic     wrOk;

  always_comb begin
    pick = SEL_NONE;
    if (hostAddr == ADDR_W'(OFF_CTRL))      pick = SEL_CTRL;
    else if (hostAddr == ADDR_W'(OFF_STAT)) pick = SEL_STAT;
    else if (hostAddr == ADDR_W'(OFF_HDST)) pick = SEL_HDST;
    else if (hostAddr == ADDR_W'(OFF_HSRC)) pick = SEL_HSRC;
    else if (hostAddr == ADDR_W'(OFF_LDST)) pick = SEL_LDST;
    else if (hostAddr == ADDR_W'(OFF_LSRC)) pick = SEL_LSRC;
    else if (hostAddr == ADDR_W'(OFF_LEN))  pick = SEL_LEN;
  end

  assign wrOk = regSel && hostWr;

  always_comb begin
    strobe.wrCtrl   = wrOk && (pick == SEL_CTRL);
    strobe.wrStat   = wrOk && (pick == SEL_STAT);
    strobe.wrCfg[0] = wrOk && (pick == SEL_HDST);
    strobe.wrCfg[1] = wrOk && (pick == SEL_HSRC);
    strobe.wrCfg[2] = wrOk && (pick == SEL_LDST);
    strobe.wrCfg[3] = wrOk && (pick == SEL_LSRC);
    strobe.wrLen    = wrOk && (pick == SEL_LEN);
    strobe.rdStrobe = regSel && hostRd;
    strobe.rdPick   = pick;
  end

endmodule

// File: rtl/dma_csr_regs.sv
module dma_csr_regs
  import dma_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  csrStrobe_t        strobe,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [1:0]        engDone,   // [0] write DMA, [1] read DMA
  output logic [1:0]        runBits,
  output logic [1:0]        doneBits,
  output logic [DATA_W-1:0] cfgOut [4],
  output logic [LEN_CODE_W-1:0] lenCode,
  output logic [DATA_W-1:0] hostRdata
);

  localparam int CFG_N = 4;

  logic [DATA_W-1:0] cfgReg [CFG_N];

  for (genvar i = 0; i < CFG_N; i++) begin : g_cfg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                cfgReg[i] <= '0;
      else if (strobe.wrCfg[i]) cfgReg[i] <= hostWdata;
    end
    assign cfgOut[i] = cfgReg[i];
  end

  for (genvar d = 0; d < 2; d++) begin : g_dir
    // Host control write outranks the engine's done pulse
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              runBits[d] <= 1'b0;
      else if (strobe.wrCtrl) runBits[d] <= hostWdata[d];
      else if (engDone[d])    runBits[d] <= 1'b0;
    end
    // A completion outranks a write-one-to-clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                doneBits[d] <= 1'b0;
      else if (engDone[d])                      doneBits[d] <= 1'b1;
      else if (strobe.wrStat && hostWdata[d])   doneBits[d] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lenCode <= '0;
    else if (strobe.wrLen) lenCode <= hostWdata[LEN_CODE_W-1:0];
  end

  logic [DATA_W-1:0] rdMux;

  always_comb begin
    rdMux = '0;
    case (strobe.rdPick)
      SEL_CTRL: rdMux = DATA_W'(runBits);
      SEL_STAT: rdMux = DATA_W'(doneBits);
      SEL_HDST: rdMux = cfgReg[0];
      SEL_HSRC: rdMux = cfgReg[1];
      SEL_LDST: rdMux = cfgReg[2];
      SEL_LSRC: rdMux = cfgReg[3];
      SEL_LEN:  rdMux = DATA_W'(lenCode);
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                hostRdata <= '0;
    else if (strobe.rdStrobe) hostRdata <= rdMux;
    else                      hostRdata <= '0;
  end

endmodule

// File: rtl/dma_csr_top.sv
module dma_csr_top
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  input  logic              wrDmaDone,
  input  logic              rdDmaDone,
  output logic              wrDmaRun,
  output logic              rdDmaRun,
  output logic [DATA_W-1:0] hostDstAddr,
  output logic [DATA_W-1:0] hostSrcAddr,
  output logic [DATA_W-1:0] localDstAddr,
  output logic [DATA_W-1:0] localSrcAddr,
  output logic [XFER_W-1:0] xferDwords
);

  csrStrobe_t            strobe;
  logic [1:0]            runBits;
  logic [1:0]            doneBits;
  logic [DATA_W-1:0]     cfgOut [4];
  logic [LEN_CODE_W-1:0] lenCode;

  dma_csr_decode #(.ADDR_W(ADDR_W)) uDec (
    .regSel   (regSel),
    .hostWr   (hostWr),
    .hostRd   (hostRd),
    .hostAddr (hostAddr),
    .strobe   (strobe)
  );

  dma_csr_regs #(.DATA_W(DATA_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .hostWdata (hostWdata),
    .engDone   ({rdDmaDone, wrDmaDone}),
    .runBits   (runBits),
    .doneBits  (doneBits),
    .cfgOut    (cfgOut),
    .lenCode   (lenCode),
    .hostRdata (hostRdata)
  );

  assign wrDmaRun     = runBits[0];
  assign rdDmaRun     = runBits[1];
  assign hostDstAddr  = cfgOut[0];
  assign hostSrcAddr  = cfgOut[1];
  assign localDstAddr = cfgOut[2];
  assign localSrcAddr = cfgOut[3];
  assign xferDwords   = policyDwords(lenCode);

endmodule

// File: rtl/dma_csr_chk.sv
module dma_csr_chk
  import dma_csr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              regSel,
  input logic              hostWr,
  input logic              hostRd,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [DATA_W-1:0] hostWdata,
  input logic [DATA_W-1:0] hostRdata,
  input logic              wrDmaDone,
  input logic              rdDmaDone,
  input logic              wrDmaRun,
  input logic              rdDmaRun,
  input logic [DATA_W-1:0] hostDstAddr,
  input logic [DATA_W-1:0] hostSrcAddr,
  input logic [DATA_W-1:0] localDstAddr,
  input logic [DATA_W-1:0] localSrcAddr,
  input logic [XFER_W-1:0] xferDwords,
  input logic [1:0]        doneBits
);

  logic ctrlWrite;
  assign ctrlWrite = regSel && hostWr && (hostAddr == ADDR_W'(OFF_CTRL));

  a_r5_wr_done_stops: assert property (@(posedge clk) disable iff (!rstN)
    (wrDmaDone && !ctrlWrite) |=> !wrDmaRun);

  a_r5_rd_done_stops: assert property (@(posedge clk) disable iff (!rstN)
    (rdDmaDone && !ctrlWrite) |=> !rdDmaRun);

  a_r4_run_holds: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWrite && !wrDmaDone && !rdDmaDone) |=> ($stable(wrDmaRun) && $stable(rdDmaRun)));

  a_r6_done_sticks: assert property (@(posedge clk) disable iff (!rstN)
    (wrDmaDone || rdDmaDone) |=> ((!$past(wrDmaDone) || doneBits[0]) && (!$past(rdDmaDone) || doneBits[1])));

  a_r8_window_blocks: assert property (@(posedge clk) disable iff (!rstN)
    !regSel |=> $stable({hostDstAddr, hostSrcAddr, localDstAddr, localSrcAddr, xferDwords}));

  a_r8_window_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !regSel) |=> (hostRdata == '0));

  a_r10_idle_read_zero: assert property (@(posedge clk) disable iff (!rstN)
    !hostRd |=> (hostRdata == '0));

  a_r3_len_legal: assert property (@(posedge clk) disable iff (!rstN)
    (xferDwords == XFER_W'(1024) || xferDwords == XFER_W'(2048) ||
     xferDwords == XFER_W'(3072) || xferDwords == XFER_W'(4096) ||
     xferDwords == XFER_W'(8192) || xferDwords == XFER_W'(16384)));

endmodule

bind dma_csr_top dma_csr_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk          (clk),
  .rstN         (rstN),
  .regSel       (regSel),
  .hostWr       (hostWr),
  .hostRd       (hostRd),
  .hostAddr     (hostAddr),
  .hostWdata    (hostWdata),
  .hostRdata    (hostRdata),
  .wrDmaDone    (wrDmaDone),
  .rdDmaDone    (rdDmaDone),
  .wrDmaRun     (wrDmaRun),
  .rdDmaRun     (rdDmaRun),
  .hostDstAddr  (hostDstAddr),
  .hostSrcAddr  (hostSrcAddr),
  .localDstAddr (localDstAddr),
  .localSrcAddr (localSrcAddr),
  .xferDwords   (xferDwords),
  .doneBits     (uDp.doneBits)
);

// File: tb/tb_dma_csr_top.sv
module tb_dma_csr_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int XFER_W = 15;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              regSel = 1'b1;
  logic              hostWr = 1'b0;
  logic              hostRd = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [DATA_W-1:0] hostWdata = '0;
  logic [DATA_W-1:0] hostRdata;
  logic              wrDmaDone = 1'b0;
  logic              rdDmaDone = 1'b0;
  logic              wrDmaRun, rdDmaRun;
  logic [DATA_W-1:0] hostDstAddr, hostSrcAddr, localDstAddr, localSrcAddr;
  logic [XFER_W-1:0] xferDwords;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_csr_top #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hWrite(input logic [7:0] a, input logic [31:0] d, input logic sel = 1'b1);
    @(negedge clk);
    regSel = sel; hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0; regSel = 1'b1;
  endtask

  task automatic hRead(input logic [7:0] a, output logic [31:0] d, input logic sel = 1'b1);
    @(negedge clk);
    regSel = sel; hostRd = 1'b1; hostAddr = a;
    @(negedge clk);
    hostRd = 1'b0; regSel = 1'b1;
    d = hostRdata;
  endtask

  task automatic pulseDone(input logic w, input logic r);
    @(negedge clk);
    wrDmaDone = w; rdDmaDone = r;
    @(negedge clk);
    wrDmaDone = 1'b0; rdDmaDone = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    chk("R1 wrDmaRun", 32'(wrDmaRun), 0);
    chk("R1 rdDmaRun", 32'(rdDmaRun), 0);
    chk("R1 hostDstAddr", hostDstAddr, 0);
    chk("R1 localSrcAddr", localSrcAddr, 0);
    chk("R1 xferDwords", 32'(xferDwords), 1024);
    for (int a = 0; a <= 'h18; a += 4) begin
      hRead(8'(a), v);
      chk("R1 reg read", v, 0);
    end
  endtask

  task automatic testConfig();
    logic [31:0] v;
    hWrite(8'h08, 32'hDEAD_0001);
    hWrite(8'h0C, 32'hBEEF_0002);
    hWrite(8'h10, 32'h1234_5678);
    hWrite(8'h14, 32'hFFFF_FFFF);
    chk("R2 hostDstAddr", hostDstAddr, 32'hDEAD_0001);
    chk("R2 hostSrcAddr", hostSrcAddr, 32'hBEEF_0002);
    chk("R2 localDstAddr", localDstAddr, 32'h1234_5678);
    chk("R2 localSrcAddr", localSrcAddr, 32'hFFFF_FFFF);
    hRead(8'h0C, v); chk("R2 readback hostSrc", v, 32'hBEEF_0002);
    hRead(8'h10, v); chk("R2 readback localDst", v, 32'h1234_5678);
  endtask

  task automatic testLength();
    logic [31:0] v;
    int exp;
    for (int c = 0; c < 8; c++) begin
      hWrite(8'h18, 32'hFFFF_FFF8 | 32'(c));
      case (c)
        1: exp = 2048; 2: exp = 3072; 3: exp = 4096;
        4: exp = 8192; 5: exp = 16384; default: exp = 1024;
      endcase
      chk("R3 xferDwords", 32'(xferDwords), 32'(exp));
      hRead(8'h18, v);
      chk("R3 code readback", v, 32'(c));
    end
  endtask

  task automatic testRunStop();
    hWrite(8'h00, 32'h1);
    chk("R4 write run set", 32'(wrDmaRun), 1);
    chk("R4 read run idle", 32'(rdDmaRun), 0);
    hWrite(8'h00, 32'h0);
    chk("R4 write run stop", 32'(wrDmaRun), 0);
  endtask

  task automatic testDone();
    logic [31:0] v;
    hWrite(8'h00, 32'h3);
    chk("R9 both running", {30'd0, rdDmaRun, wrDmaRun}, 3);
    pulseDone(1'b1, 1'b0);
    chk("R5 write run cleared", 32'(wrDmaRun), 0);
    chk("R9 read run kept", 32'(rdDmaRun), 1);
    hRead(8'h04, v); chk("R6 write done sticky", v, 1);
    pulseDone(1'b0, 1'b1);
    chk("R5 read run cleared", 32'(rdDmaRun), 0);
    hRead(8'h04, v); chk("R6 both done", v, 3);
    hWrite(8'h04, 32'h1);
    hRead(8'h04, v); chk("R6 w1c bit0", v, 2);
    hWrite(8'h04, 32'h0);
    hRead(8'h04, v); chk("R6 write 0 no effect", v, 2);
    hWrite(8'h04, 32'h2);
    hRead(8'h04, v); chk("R6 w1c bit1", v, 0);
  endtask

  task automatic testCollide();
    logic [31:0] v;
    hWrite(8'h00, 32'h1);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = 8'h00; hostWdata = 32'h1; wrDmaDone = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; wrDmaDone = 1'b0;
    chk("R5 host write beats done", 32'(wrDmaRun), 1);
    hRead(8'h04, v); chk("R6 done set", v, 1);
    @(negedge clk);
    hostWr = 1'b1; hostAddr = 8'h04; hostWdata = 32'h1; wrDmaDone = 1'b1;
    @(negedge clk);
    hostWr = 1'b0; wrDmaDone = 1'b0;
    hRead(8'h04, v); chk("R6 set beats clear", v, 1);
    hWrite(8'h04, 32'h3);
    hWrite(8'h00, 32'h0);
  endtask

  task automatic testUnmapped();
    logic [31:0] v;
    hWrite(8'h0D, 32'h5555_5555);
    chk("R7 misaligned write ignored", hostSrcAddr, 32'hBEEF_0002);
    hWrite(8'h01, 32'h3);
    chk("R7 misaligned ctrl ignored", {30'd0, rdDmaRun, wrDmaRun}, 0);
    hWrite(8'h1C, 32'hAAAA_AAAA);
    hRead(8'h1C, v); chk("R7 unmapped read", v, 0);
    hRead(8'h0D, v); chk("R7 misaligned read", v, 0);
    hRead(8'h40, v); chk("R7 far offset read", v, 0);
  endtask

  task automatic testWindow();
    logic [31:0] v;
    hWrite(8'h08, 32'h0BAD_F00D, 1'b0);
    chk("R8 deselected write ignored", hostDstAddr, 32'hDEAD_0001);
    hWrite(8'h00, 32'h3, 1'b0);
    chk("R8 deselected ctrl ignored", {30'd0, rdDmaRun, wrDmaRun}, 0);
    hRead(8'h08, v, 1'b0); chk("R8 deselected read zero", v, 0);
  endtask

  task automatic testIdle();
    logic [31:0] v;
    hRead(8'h08, v); chk("R10 read latency", v, 32'hDEAD_0001);
    @(negedge clk);
    chk("R10 idle read data zero", hostRdata, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testConfig();
    testLength();
    testRunStop();
    testDone();
    testCollide();
    testUnmapped();
    testWindow();
    testIdle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule